// File: doc/BRIEF.md
# Multiplexed GPIO Bank Controller

This block controls one bank of up to 32 general-purpose pins through a small word-addressed register port. Each pin either stays under direct I/O control or is handed to one of two internal peripherals. Every per-pin attribute is changed only through a pair of strobe words. Writing a 1 to the set word turns the attribute on for that pin, writing a 1 to the clear word turns it off, and 0 bits leave the pin alone. A third, read-only word returns the current value of the attribute.

On the pad side the bank produces an output level, an output enable and a pull-up request for every pin. An open-drain option lets a pin only pull low. On the input side each pad passes through a synchroniser and then an optional per-pin glitch filter. A change detector watches both edges and records every change in a sticky status word. The block ORs the masked status bits into one interrupt line.

A driver first picks the pin's role, then sets its output, pull and filter attributes, and then unmasks its interrupt. The interrupt handler reads the status word, and that read clears it.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset every pin is in direct I/O role with its output disabled and its level low. Pull-up is on for every pin. Filter, open-drain and interrupt enable are off, and peripheral A is selected. The change status is zero and `irq` is low.
- R2: Attribute k (0 I/O role, 1 output enable, 2 output level, 3 pull-up, 4 filter, 5 open-drain, 6 interrupt enable, 7 peripheral B select) has its set word at offset 3k, its clear word at 3k+1 and its read-only value at 3k+2. Only the 1 bits of a strobe change pins. The set and clear words read as zero.
- R3: In direct I/O role, `pad_out` follows the pin's output level and `pad_oe` follows its output enable.
- R4: In peripheral role, the pin carries `pa_out`/`pa_oe` when its B select bit is 0 and `pb_out`/`pb_oe` when the bit is 1.
- R5: With open-drain on, `pad_out` is 0 and `pad_oe` is asserted only while the role's drive enable is 1 and its drive level is 0.
- R6: `pad_pull_en` mirrors the pull-up attribute of each pin.
- R7: A read of offset 24 returns the synchronised pad levels of all pins, whatever their role. A pad change is visible there two clocks after it reaches `pad_in`.
- R8: Every rising and falling edge of a pin's conditioned input sets its bit in the change status at offset 25, whether or not the pin is masked. Without the filter, the bit and `irq` rise on the fourth clock edge after the pad changes. A bit never clears except by a read.
- R9: A read of offset 25 returns the status and clears every bit that no new change sets in the same cycle. Read data appears on `rdata` one clock after `rd_en`.
- R10: `irq` is high exactly when some pin has both its status bit and its interrupt enable set.
- R11: With the filter on, a synchronised level is accepted only after it has been equal on two consecutive clocks. A one-clock pad pulse therefore records no change, while a held level records one. Without the filter the same pulse records a change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word offset |
| wdata | input | DATA_W | Write data (one bit per pin) |
| rdata | output | DATA_W | Registered read data |
| pad_in | input | NUM_PINS | Pad input levels |
| pad_out | output | NUM_PINS | Pad output levels |
| pad_oe | output | NUM_PINS | Pad output enables |
| pad_pull_en | output | NUM_PINS | Pull-up requests |
| pa_out | input | NUM_PINS | Peripheral A output levels |
| pa_oe | input | NUM_PINS | Peripheral A output enables |
| pb_out | input | NUM_PINS | Peripheral B output levels |
| pb_oe | input | NUM_PINS | Peripheral B output enables |
| irq | output | 1 | Combined pin-change interrupt |

## Verification
Properties checked on every cycle:
- an open-drain pin never drives high;
- an input-configured I/O pin never enables its driver;
- `irq` stays low while the mask is empty;
- status bits stay set until a status read;
- a status read returns the status and a set strobe lands.

Only the bench scenarios show the rest:
- the full role and open-drain mux, swept across all pins and peripheral pattern combinations;
- the exact interrupt latency;
- suppression of a one-clock pulse by the filter, and its passage without the filter;
- the pin-level read;
- clearing of the status by a read.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
   localparam int unsigned NUM_ATTR      = 8;
   localparam int unsigned WORDS_PER_ATTR = 3;
   localparam int unsigned ATTR_IO   = 0;
   localparam int unsigned ATTR_OE   = 1;
   localparam int unsigned ATTR_LVL  = 2;
   localparam int unsigned ATTR_PULL = 3;
   localparam int unsigned ATTR_FILT = 4;
   localparam int unsigned ATTR_MD   = 5;
   localparam int unsigned ATTR_IE   = 6;
   localparam int unsigned ATTR_SELB = 7;
   localparam int unsigned OFS_PINLVL = NUM_ATTR * WORDS_PER_ATTR;
   localparam int unsigned OFS_CHG    = OFS_PINLVL + 1;

   function automatic logic attr_reset_val(int unsigned k);
      return (k == ATTR_IO) || (k == ATTR_PULL);
   endfunction
endpackage

// File: rtl/pinbank_regs.sv
module pinbank_regs
   import pinbank_pkg::*;
#(
   parameter int unsigned N      = 32,
   parameter int unsigned ADDR_W = 5
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [N-1:0]                  wdata,
   output logic [NUM_ATTR-1:0][N-1:0]    attr_q
);
   for (genvar k = 0; k < NUM_ATTR; k++) begin : g_attr
      localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(k * WORDS_PER_ATTR);
      localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(k * WORDS_PER_ATTR + 1);
      localparam logic              RST_V = attr_reset_val(k);
      logic [N-1:0] q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= {N{RST_V}};
         else if (wr_en && addr == SET_A)
            q <= q | wdata;
         else if (wr_en && addr == CLR_A)
            q <= q & ~wdata;
      end

      assign attr_q[k] = q;
   end
endmodule

// File: rtl/pinbank_padmux.sv
module pinbank_padmux #(
   parameter int unsigned N = 32
) (
   input  logic [N-1:0] io,
   input  logic [N-1:0] oe,
   input  logic [N-1:0] lvl,
   input  logic [N-1:0] md,
   input  logic [N-1:0] selb,
   input  logic [N-1:0] pa_out,
   input  logic [N-1:0] pa_oe,
   input  logic [N-1:0] pb_out,
   input  logic [N-1:0] pb_oe,
   output logic [N-1:0] pad_out,
   output logic [N-1:0] pad_oe
);
   for (genvar i = 0; i < N; i++) begin : g_pin
      logic per_val, per_en, drv_val, drv_en;
      assign per_val = selb[i] ? pb_out[i] : pa_out[i];
      assign per_en  = selb[i] ? pb_oe[i]  : pa_oe[i];
      assign drv_val = io[i] ? lvl[i] : per_val;
      assign drv_en  = io[i] ? oe[i]  : per_en;
      assign pad_out[i] = md[i] ? 1'b0 : drv_val;
      assign pad_oe[i]  = md[i] ? (drv_en & ~drv_val) : drv_en;
   end
endmodule

// File: rtl/pinbank_infilt.sv
module pinbank_infilt #(
   parameter int unsigned N           = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pad_in,
   input  logic [N-1:0] filt_en,
   output logic [N-1:0] lvl_sync,
   output logic [N-1:0] chg
);
   logic [SYNC_STAGES-1:0][N-1:0] st;
   logic [N-1:0] prev, clean, clean_d, stable;

   assign lvl_sync = st[SYNC_STAGES-1];
   assign stable   = ~(lvl_sync ^ prev);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= '0;
         prev    <= '0;
         clean   <= '0;
         clean_d <= '0;
      end else begin
         st      <= {st[SYNC_STAGES-2:0], pad_in};
         prev    <= lvl_sync;
         clean   <= (filt_en & ((stable & lvl_sync) | (~stable & clean)))
                  | (~filt_en & lvl_sync);
         clean_d <= clean;
      end
   end

   assign chg = clean ^ clean_d;
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
   import pinbank_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 rd_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    wdata,
   output logic [DATA_W-1:0]    rdata,
   input  logic [NUM_PINS-1:0]  pad_in,
   output logic [NUM_PINS-1:0]  pad_out,
   output logic [NUM_PINS-1:0]  pad_oe,
   output logic [NUM_PINS-1:0]  pad_pull_en,
   input  logic [NUM_PINS-1:0]  pa_out,
   input  logic [NUM_PINS-1:0]  pa_oe,
   input  logic [NUM_PINS-1:0]  pb_out,
   input  logic [NUM_PINS-1:0]  pb_oe,
   output logic                 irq
);
   localparam logic [ADDR_W-1:0] PINLVL_A = ADDR_W'(OFS_PINLVL);
   localparam logic [ADDR_W-1:0] CHG_A    = ADDR_W'(OFS_CHG);

   if (NUM_PINS < 1 || NUM_PINS > DATA_W) begin : g_bad_pins
      initial $fatal(1, "NUM_PINS must lie in 1..DATA_W");
   end
   if ((1 << ADDR_W) <= OFS_CHG) begin : g_bad_addr
      initial $fatal(1, "ADDR_W too narrow for register map");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      initial $fatal(1, "SYNC_STAGES must be at least 2");
   end

   logic [NUM_ATTR-1:0][NUM_PINS-1:0] attr_q;
   logic [NUM_PINS-1:0] io_q, oe_q, md_q, ie_q;
   logic [NUM_PINS-1:0] lvl_sync, chg_now, chg_stat, rd_next;
   logic                rd_chg;

   pinbank_regs #(.N(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wdata(wdata[NUM_PINS-1:0]), .attr_q(attr_q)
   );

   assign io_q = attr_q[ATTR_IO];
   assign oe_q = attr_q[ATTR_OE];
   assign md_q = attr_q[ATTR_MD];
   assign ie_q = attr_q[ATTR_IE];
   assign pad_pull_en = attr_q[ATTR_PULL];

   pinbank_padmux #(.N(NUM_PINS)) u_mux (
      .io(io_q), .oe(oe_q), .lvl(attr_q[ATTR_LVL]), .md(md_q),
      .selb(attr_q[ATTR_SELB]), .pa_out(pa_out), .pa_oe(pa_oe),
      .pb_out(pb_out), .pb_oe(pb_oe), .pad_out(pad_out), .pad_oe(pad_oe)
   );

   pinbank_infilt #(.N(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_in (
      .clk(clk), .rst_n(rst_n), .pad_in(pad_in),
      .filt_en(attr_q[ATTR_FILT]), .lvl_sync(lvl_sync), .chg(chg_now)
   );

   assign rd_chg = rd_en && (addr == CHG_A);

   always_comb begin
      rd_next = '0;
      for (int k = 0; k < NUM_ATTR; k++)
         if (addr == ADDR_W'(k * WORDS_PER_ATTR + 2))
            rd_next = attr_q[k];
      if (addr == PINLVL_A) rd_next = lvl_sync;
      if (addr == CHG_A)    rd_next = chg_stat;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chg_stat <= '0;
         rdata    <= '0;
      end else begin
         chg_stat <= (rd_chg ? '0 : chg_stat) | chg_now;
         rdata    <= rd_en ? DATA_W'(rd_next) : '0;
      end
   end

   assign irq = |(chg_stat & ie_q);
endmodule

// File: rtl/pinbank_ctrl_chk.sv
module pinbank_ctrl_chk
   import pinbank_pkg::*;
#(
   parameter int unsigned N      = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic [N-1:0]      pad_out,
   input logic [N-1:0]      pad_oe,
   input logic              irq,
   input logic [N-1:0]      io,
   input logic [N-1:0]      oe,
   input logic [N-1:0]      md,
   input logic [N-1:0]      ie,
   input logic [N-1:0]      status
);
   localparam logic [ADDR_W-1:0] CHG_A  = ADDR_W'(OFS_CHG);
   localparam logic [ADDR_W-1:0] IE_SET = ADDR_W'(ATTR_IE * WORDS_PER_ATTR);

   assert_md_never_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (md & pad_oe & pad_out) == '0);

   assert_input_undriven_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (io & ~oe & pad_oe) == '0);

   assert_mask_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ie == '0) |-> !irq);

   assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && addr == CHG_A) |=> (($past(status) & ~status) == '0));

   assert_read_returns_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == CHG_A) |=> (rdata[N-1:0] == $past(status)));

   assert_set_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == IE_SET) |=> ((ie & $past(wdata[N-1:0])) == $past(wdata[N-1:0])));
endmodule

bind pinbank_ctrl pinbank_ctrl_chk #(.N(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
   .wdata(wdata), .rdata(rdata), .pad_out(pad_out), .pad_oe(pad_oe),
   .irq(irq), .io(io_q), .oe(oe_q), .md(md_q), .ie(ie_q), .status(chg_stat)
);

// File: tb/pinbank_ctrl_tb.sv
`timescale 1ns/1ps
module pinbank_ctrl_tb;
   localparam int N = 32;
   logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
   logic [4:0] addr = '0;
   logic [31:0] wdata = '0, rdata;
   logic [N-1:0] pad_in = '0, pad_out, pad_oe, pad_pull_en;
   logic [N-1:0] pa_out = 32'h0F0F0F0F, pa_oe = 32'h00FF00FF;
   logic [N-1:0] pb_out = 32'h33333333, pb_oe = 32'h55555555;
   logic irq;
   int checks = 0, errors = 0;
   logic done = 0;

   always #10 clk = ~clk;

   pinbank_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
      .pad_oe(pad_oe), .pad_pull_en(pad_pull_en), .pa_out(pa_out),
      .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe), .irq(irq)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(int a, logic [31:0] d);
      @(negedge clk); wr_en = 1; addr = 5'(a); wdata = d;
      @(negedge clk); wr_en = 0;
   endtask

   task automatic rd(int a, output logic [31:0] d);
      @(negedge clk); rd_en = 1; addr = 5'(a);
      @(negedge clk); rd_en = 0; d = rdata;
   endtask

   task automatic put(int k, logic on);
      wr(3 * k + (on ? 0 : 1), 32'hFFFF_FFFF);
   endtask

   initial begin
      logic [31:0] d;
      logic [31:0] eo, ee;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset values of every attribute
      for (int k = 0; k < 8; k++) begin
         rd(3 * k + 2, d);
         check("R1", d, (k == 0 || k == 3) ? 32'hFFFF_FFFF : 32'h0);
      end
      check("R1", pad_oe, 32'h0);
      check("R1", {31'b0, irq}, 32'h0);
      rd(25, d); check("R1", d, 32'h0);
      // R2: strobes touch only 1 bits; strobe words read zero
      wr(18, 32'h0000_00F0);
      wr(19, 32'h0000_0030);
      rd(20, d); check("R2", d, 32'h0000_00C0);
      rd(18, d); check("R2", d, 32'h0);
      rd(1, d);  check("R2", d, 32'h0);
      wr(19, 32'hFFFF_FFFF);
      // R3 R4 R5: sweep role / oe / level / open-drain / select
      for (int c = 0; c < 32; c++) begin
         put(0, c[0]); put(1, c[1]); put(2, c[2]); put(5, c[3]); put(7, c[4]);
         for (int i = 0; i < N; i++) begin
            logic dv, de;
            dv = c[0] ? c[2] : (c[4] ? pb_out[i] : pa_out[i]);
            de = c[0] ? c[1] : (c[4] ? pb_oe[i] : pa_oe[i]);
            eo[i] = c[3] ? 1'b0 : dv;
            ee[i] = c[3] ? (de & ~dv) : de;
         end
         check(c[3] ? "R5 out" : (c[0] ? "R3 out" : "R4 out"), pad_out, eo);
         check(c[3] ? "R5 oe"  : (c[0] ? "R3 oe"  : "R4 oe"),  pad_oe,  ee);
      end
      put(0, 1); put(1, 0); put(2, 0); put(5, 0); put(7, 0);
      // R6: pull-up mirror
      wr(10, 32'hFFFF_0000);
      check("R6", pad_pull_en, 32'h0000_FFFF);
      wr(9, 32'hFFFF_0000);
      check("R6", pad_pull_en, 32'hFFFF_FFFF);
      // R7: pin level two clocks after a change
      @(negedge clk); pad_in = 32'hA5C3_0F96;
      @(negedge clk); rd_en = 1; addr = 5'd24;
      @(negedge clk); rd_en = 0;
      check("R7 early", rdata, 32'h0);
      rd(24, d); check("R7", d, 32'hA5C3_0F96);
      repeat (4) @(negedge clk);
      check("R10 masked", {31'b0, irq}, 32'h0);
      rd(25, d); check("R8 masked", d, 32'hA5C3_0F96);
      rd(25, d); check("R9 cleared", d, 32'h0);
      // R8 R10: exact latency on an enabled pin
      wr(18, 32'h0000_0008);
      @(negedge clk); pad_in[3] = ~pad_in[3];
      repeat (3) @(posedge clk);
      @(negedge clk); check("R8 latency", {31'b0, irq}, 32'h0);
      @(posedge clk);
      @(negedge clk); check("R10 irq", {31'b0, irq}, 32'h1);
      rd(25, d); check("R9 read", d, 32'h0000_0008);
      check("R9 irq drop", {31'b0, irq}, 32'h0);
      // R8: masked pin still latched
      @(negedge clk); pad_in[5] = ~pad_in[5];
      repeat (6) @(negedge clk);
      check("R10 masked pin", {31'b0, irq}, 32'h0);
      rd(25, d); check("R8 masked pin", d, 32'h0000_0020);
      // R11: filter suppresses one-clock pulse, passes held level
      wr(12, 32'h0000_0080);
      @(negedge clk); pad_in[7] = ~pad_in[7];
      @(negedge clk); pad_in[7] = ~pad_in[7];
      repeat (8) @(negedge clk);
      rd(25, d); check("R11 pulse filtered", d, 32'h0);
      @(negedge clk); pad_in[7] = ~pad_in[7];
      repeat (8) @(negedge clk);
      rd(25, d); check("R11 held level", d, 32'h0000_0080);
      @(negedge clk); pad_in[9] = ~pad_in[9];
      @(negedge clk); pad_in[9] = ~pad_in[9];
      repeat (8) @(negedge clk);
      rd(25, d); check("R11 unfiltered pulse", d, 32'h0000_0200);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule